// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a level-1 data cache controller between a word-wide processor load/store port and a simple next-level memory port. By default it holds 32 KB in 4 ways of 32-byte lines, which gives 256 sets. Each line carries a tag, a valid bit and a dirty bit. Read and store hits finish in the cache. A store hit only updates the cached copy. A miss on a load or a store picks a victim way. If that victim is dirty, the controller first writes it back as eight word beats. It then refills the line with eight word beats and retries the request, which now hits. Stores therefore allocate a line on a miss.

Addresses above a configured limit (by default 0x3FFFFFFF) are not cacheable. Each such access becomes exactly one word transfer on the memory port and never touches the tag state, so every read of a device register sees its live value. A one-cycle miss pulse is raised for each cacheable miss. Profiling counters outside the block can count these pulses.

Victim choice fills empty ways first, lowest way number first. Once the set is full, the victim comes from the low bits of a free-running 16-bit LFSR. Tags and data are behavioural arrays. The control is a single FSM handling one miss at a time.

Top module: `dcache_wb`

## Requirements
- R1: The geometry is derived from parameters: sets = CAP_BYTES / (WAYS × LINE_BYTES). The byte offset is the low log2(LINE_BYTES) address bits, the set index is the next log2(sets) bits, and the tag is the remaining upper bits. Lines in different sets never evict each other.
- R2: Reset clears every valid bit and every dirty bit, so the first access to any cacheable line after reset is a miss. During reset, cpu_ready, cpu_rvalid, miss_pulse and mem_valid are all 0.
- R3: For a cacheable read that hits, cpu_ready is high in the same cycle as cpu_valid. The request is accepted on that clock edge. cpu_rvalid is 1 with the word in cpu_rdata for exactly the next cycle. A hit causes no memory-port traffic. cpu_rvalid stays 0 after an accepted store.
- R4: A store hit merges cpu_wdata into the cached word under cpu_be (bit i selects bits 8i+7:8i). It marks the line dirty and issues no memory write.
- R5: A store miss refills the whole line (8 read beats) and then performs the store in the cache. The next-level copy of the stored word keeps its old value.
- R6: On a miss, the victim is the lowest-numbered invalid way in the set. If every way is valid, the victim is the way given by the low log2(WAYS) bits of a free-running 16-bit LFSR, which is never zero.
- R7: A dirty victim is written back as 8 beats, in ascending word order at the victim's own line address with all byte enables set, before the first refill beat. A clean victim causes no write.
- R8: An access with address above UNC_LIMIT performs exactly one word transfer at the word-aligned address, using the request's direction and byte enables. It never allocates or changes any line, and a repeated read returns the current next-level value.
- R9: miss_pulse is high for exactly one cycle per cacheable miss, and never for hits or uncached accesses.
- R10: A memory beat completes on a clock edge where mem_valid and mem_ready are both 1. While mem_ready is 0, mem_valid and mem_addr hold their values.
- R11: During a miss, cpu_ready stays 0 until the refill has completed. The processor holds its request stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_be | input | 4 | Byte enables for stores |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request accepted on this edge |
| cpu_rvalid | output | 1 | Load data valid, the cycle after acceptance |
| cpu_rdata | output | 32 | Load data |
| miss_pulse | output | 1 | One-cycle pulse per cacheable miss |
| mem_valid | output | 1 | Memory beat requested |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables of the memory beat |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory beat completes on this edge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The interesting overlap is a store hit that sets a line's dirty bit and writes its data word in one cycle, while the very next request misses in the same set and picks that line as victim. The write-back then reads the data array one cycle after it was written. The bench provokes this by dirtying all four ways of a set with back-to-back stores and then issuing a store miss to a fifth tag. Memory acknowledgements are stalled on every third cycle throughout. The bench judges the outcome by checking that the eight written-back words equal its own golden copy of the line, that they appear in ascending order before any refill beat, and that the backing copy of the newly stored word stays stale.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int DATA_W     = 32;
    localparam int WORD_BYTES = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_UNC,
        ST_UNC_DONE
    } dc_state_e;

endpackage

// File: rtl/dc_lfsr.sv
module dc_lfsr #(
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] value
);

    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q[OUT_W-1:0];

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000);

endmodule

// File: rtl/dc_victim_sel.sv
module dc_victim_sel #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_row,
    input  logic [WAY_W-1:0] rnd,
    output logic [WAY_W-1:0] way
);

    logic found;

    always_comb begin
        way   = rnd;
        found = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!valid_row[i] && !found) begin
                way   = WAY_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dc_way_store.sv
module dc_way_store #(
    parameter int SETS = 256,
    parameter int WPL  = 8,
    parameter int DW   = 32
) (
    input  logic                             clk,
    input  logic                             wr_en,
    input  logic [$clog2(SETS*WPL)-1:0]      wr_idx,
    input  logic [DW/8-1:0]                  wr_be,
    input  logic [DW-1:0]                    wr_data,
    input  logic [$clog2(SETS*WPL)-1:0]      rd_idx_a,
    output logic [DW-1:0]                    rd_data_a,
    input  logic [$clog2(SETS*WPL)-1:0]      rd_idx_b,
    output logic [DW-1:0]                    rd_data_b
);

    localparam int DEPTH = SETS * WPL;
    localparam int BE_W  = DW / 8;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) mem_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    assign rd_data_a = mem_q[rd_idx_a];
    assign rd_data_b = mem_q[rd_idx_b];

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
    import dc_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CAP_BYTES  = 32768,
    parameter int                WAYS       = 4,
    parameter int                LINE_BYTES = 32,
    parameter logic [ADDR_W-1:0] UNC_LIMIT  = 32'h3FFF_FFFF,
    parameter logic [15:0]       LFSR_SEED  = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_valid,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_ready,
    output logic                cpu_rvalid,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                miss_pulse,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [DATA_W-1:0]   mem_rdata
);

    localparam int WPL    = LINE_BYTES / WORD_BYTES;
    localparam int SETS   = CAP_BYTES / (LINE_BYTES * WAYS);
    localparam int BYTE_W = $clog2(WORD_BYTES);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WSEL_W = $clog2(WPL);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int BE_W   = DATA_W / 8;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPL - 1);

    typedef struct packed {
        dc_state_e             st;
        logic [WSEL_W-1:0]     beat;
        logic [WAY_W-1:0]      way;
        logic [SET_W-1:0]      set;
        logic [TAG_W-1:0]      new_tag;
        logic [TAG_W-1:0]      old_tag;
        logic [ADDR_W-BYTE_W-1:0] unc_word;
        logic                  unc_we;
        logic [BE_W-1:0]       unc_be;
        logic [DATA_W-1:0]     unc_wdata;
        logic [DATA_W-1:0]     unc_rdata;
        logic [DATA_W-1:0]     rdata;
        logic                  rvalid;
        logic                  miss;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // line state
    logic [WAYS-1:0][SETS-1:0] valid_q;
    logic [WAYS-1:0][SETS-1:0] dirty_q;
    logic [TAG_W-1:0]          tag_q [WAYS][SETS];

    // request decode
    logic [TAG_W-1:0]  req_tag;
    logic [SET_W-1:0]  req_set;
    logic [WSEL_W-1:0] req_word;
    logic              uncached;
    logic [BYTE_W-1:0] unused_addr_lo;

    assign req_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_set        = cpu_addr[OFF_W +: SET_W];
    assign req_word       = cpu_addr[BYTE_W +: WSEL_W];
    assign uncached       = cpu_addr > UNC_LIMIT;
    assign unused_addr_lo = cpu_addr[BYTE_W-1:0];

    // lookup
    logic              hit_any, cache_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAYS-1:0]   valid_row;

    always_comb begin
        hit_any = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            valid_row[w] = valid_q[w][req_set];
            if (valid_q[w][req_set] && tag_q[w][req_set] == req_tag) begin
                hit_any = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    assign cache_hit = hit_any && !uncached;

    // victim choice
    logic [WAY_W-1:0] rnd_way, victim_way;

    dc_lfsr #(.SEED(LFSR_SEED), .OUT_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd_way)
    );

    dc_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_row (valid_row),
        .rnd       (rnd_way),
        .way       (victim_way)
    );

    // datapath controls
    logic                    store_hit, fill_beat, fill_last, cpu_accept;
    logic [SET_W+WSEL_W-1:0] wr_idx;
    logic [BE_W-1:0]         wr_be;
    logic [DATA_W-1:0]       wr_data;
    logic [DATA_W-1:0]       rd_a [WAYS];
    logic [DATA_W-1:0]       rd_b [WAYS];

    assign cpu_ready  = (ctl_q.st == ST_IDLE && cpu_valid && cache_hit) ||
                        (ctl_q.st == ST_UNC_DONE);
    assign cpu_accept = cpu_valid && cpu_ready;
    assign store_hit  = ctl_q.st == ST_IDLE && cpu_valid && cache_hit && cpu_we;
    assign fill_beat  = ctl_q.st == ST_FILL && mem_ready;
    assign fill_last  = fill_beat && ctl_q.beat == LAST_BEAT;
    assign wr_idx     = fill_beat ? {ctl_q.set, ctl_q.beat} : {req_set, req_word};
    assign wr_be      = fill_beat ? {BE_W{1'b1}} : cpu_be;
    assign wr_data    = fill_beat ? mem_rdata : cpu_wdata;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic we_w;
        assign we_w = (fill_beat && ctl_q.way == WAY_W'(w)) ||
                      (store_hit && hit_way == WAY_W'(w));

        dc_way_store #(.SETS(SETS), .WPL(WPL), .DW(DATA_W)) u_store (
            .clk       (clk),
            .wr_en     (we_w),
            .wr_idx    (wr_idx),
            .wr_be     (wr_be),
            .wr_data   (wr_data),
            .rd_idx_a  ({req_set, req_word}),
            .rd_data_a (rd_a[w]),
            .rd_idx_b  ({ctl_q.set, ctl_q.beat}),
            .rd_data_b (rd_b[w])
        );
    end

    // next-state logic
    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.miss   = 1'b0;
        ctl_d.rvalid = 1'b0;

        if (cpu_accept && !cpu_we) begin
            ctl_d.rvalid = 1'b1;
            ctl_d.rdata  = (ctl_q.st == ST_UNC_DONE) ? ctl_q.unc_rdata : rd_a[hit_way];
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_valid && !cache_hit) begin
                    if (uncached) begin
                        ctl_d.st        = ST_UNC;
                        ctl_d.unc_word  = cpu_addr[ADDR_W-1:BYTE_W];
                        ctl_d.unc_we    = cpu_we;
                        ctl_d.unc_be    = cpu_be;
                        ctl_d.unc_wdata = cpu_wdata;
                    end else begin
                        ctl_d.miss    = 1'b1;
                        ctl_d.way     = victim_way;
                        ctl_d.set     = req_set;
                        ctl_d.new_tag = req_tag;
                        ctl_d.old_tag = tag_q[victim_way][req_set];
                        ctl_d.beat    = '0;
                        ctl_d.st      = (valid_q[victim_way][req_set] &&
                                         dirty_q[victim_way][req_set]) ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ready) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) ctl_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ready) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) ctl_d.st = ST_IDLE;
                end
            end
            ST_UNC: begin
                if (mem_ready) begin
                    ctl_d.unc_rdata = mem_rdata;
                    ctl_d.st        = ST_UNC_DONE;
                end
            end
            ST_UNC_DONE: begin
                if (cpu_valid) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // line state update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_last) begin
                valid_q[ctl_q.way][ctl_q.set] <= 1'b1;
                dirty_q[ctl_q.way][ctl_q.set] <= 1'b0;
            end
            if (store_hit) dirty_q[hit_way][req_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_last) tag_q[ctl_q.way][ctl_q.set] <= ctl_q.new_tag;
    end

    // memory port
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        unique case (ctl_q.st)
            ST_WBACK: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ctl_q.old_tag, ctl_q.set, ctl_q.beat, {BYTE_W{1'b0}}};
                mem_be    = {BE_W{1'b1}};
                mem_wdata = rd_b[ctl_q.way];
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {ctl_q.new_tag, ctl_q.set, ctl_q.beat, {BYTE_W{1'b0}}};
                mem_be    = {BE_W{1'b1}};
            end
            ST_UNC: begin
                mem_valid = 1'b1;
                mem_we    = ctl_q.unc_we;
                mem_addr  = {ctl_q.unc_word, {BYTE_W{1'b0}}};
                mem_be    = ctl_q.unc_be;
                mem_wdata = ctl_q.unc_wdata;
            end
            default: ;
        endcase
    end

    assign cpu_rvalid = ctl_q.rvalid;
    assign cpu_rdata  = ctl_q.rdata;
    assign miss_pulse = ctl_q.miss;

    // R9
    miss_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |=> !miss_pulse);

    // R9
    miss_not_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_UNC) |-> !miss_pulse);

    // R8
    bypass_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_UNC || ctl_q.st == ST_UNC_DONE) |=> $stable(valid_q));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    // R4
    store_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_accept && cpu_we && ctl_q.st == ST_IDLE) |=> !mem_valid);

    // R11
    ready_no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_valid);

    // R5
    fill_installs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |=> (valid_q[ctl_q.way][ctl_q.set] && !dirty_q[ctl_q.way][ctl_q.set]));

endmodule

// File: tb/sim_dcache_wb.sv
module sim_dcache_wb;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 256;   // 2 sets x 4 ways x 32 B
    localparam logic [31:0] LIM = 32'h3FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready, cpu_rvalid, miss_pulse;
    logic [31:0] cpu_rdata;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    dcache_wb #(.CAP_BYTES(CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .miss_pulse(miss_pulse), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] bmem [0:1023];   // next-level copy
    logic [31:0] gold [0:1023];   // processor-visible view
    logic [31:0] dev  [0:3];      // uncached registers
    logic [31:0] wr_log [0:15];
    int nvec = 0, nfail = 0;
    int miss_seen = 0, miss_inferred = 0;
    int wr_beats = 0, rd_beats = 0, seqn = 0, wr_log_n = 0;
    int last_wr_seq = 0, first_rd_seq = 0, mcnt = 0;

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] la(int tag, int set, int word);
        return 32'((tag << 6) | (set << 5) | (word << 2));
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: decides ready at negedge, commits the beat that completes at next posedge
    always @(negedge clk) begin
        logic rr;
        logic [31:0] a;
        rr = (mcnt % 3) != 2;
        mcnt++;
        if (rst_n && mem_valid && rr) begin
            a = mem_addr;
            seqn++;
            if (mem_we) begin
                if (a > LIM) dev[a[3:2]] = merge(dev[a[3:2]], mem_wdata, mem_be);
                else         bmem[a[11:2]] = merge(bmem[a[11:2]], mem_wdata, mem_be);
                if (wr_log_n < 16) wr_log[wr_log_n] = a;
                wr_log_n++;
                wr_beats++;
                last_wr_seq = seqn;
            end else begin
                mem_rdata = (a > LIM) ? dev[a[3:2]] : bmem[a[11:2]];
                rd_beats++;
                if (first_rd_seq == 0) first_rd_seq = seqn;
            end
        end
        mem_ready = rr;
    end

    always @(negedge clk) if (rst_n && miss_pulse) miss_seen++;

    // one processor access, called at a negedge, returns at a negedge
    task automatic access(input logic we, input logic [31:0] addr, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
        logic [31:0] exp;
        bit cacheable;
        cacheable = addr <= LIM;
        exp = cacheable ? gold[addr[11:2]] : dev[addr[3:2]];
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 5000) begin
            @(negedge clk); #1;
            waits++;
        end
        chk(waits < 5000, "R11 request never accepted", 32'(waits), 32'd5000);
        @(posedge clk);
        @(negedge clk);
        rd = cpu_rdata;
        chk(cpu_rvalid === !we, "R3 rvalid after accept", 32'(cpu_rvalid), 32'(!we));
        if (!we) chk(rd === exp, cacheable ? "R3 read data" : "R8 live read data", rd, exp);
        cpu_valid = 1'b0;
        if (cacheable && waits > 0) miss_inferred++;
        if (cacheable && we) gold[addr[11:2]] = merge(gold[addr[11:2]], wd, be);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd, wd, vaddr;
        int w, m0, wb0, rb0, r;
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = 32'hA5A5_0000 ^ (i * 32'h0001_0101);
            gold[i] = bmem[i];
        end
        for (int i = 0; i < 4; i++) dev[i] = 32'hD000_0000 + i;

        repeat (3) @(negedge clk);
        // R2 reset state
        chk(cpu_ready == 0 && cpu_rvalid == 0, "R2 reset outputs", {cpu_ready, cpu_rvalid}, 0);
        chk(miss_pulse == 0 && mem_valid == 0, "R2 reset mem/miss", {miss_pulse, mem_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R6 R9 R11: four lines into empty set 0
        for (int t = 0; t < 4; t++) begin
            m0 = miss_seen;
            access(1'b0, la(t, 0, 0), 4'h0, 0, rd, w);
            chk(w >= 8, "R11 miss stalls through refill", 32'(w), 32'd8);
            chk(miss_seen == m0 + 1, "R9 one pulse per miss", 32'(miss_seen), 32'(m0 + 1));
        end
        chk(wr_beats == 0, "R7 clean victims not written", 32'(wr_beats), 0);
        for (int t = 0; t < 4; t++) begin
            access(1'b0, la(t, 0, 3), 4'h0, 0, rd, w);
            chk(w == 0, "R6 invalid ways filled first, all resident", 32'(w), 0);
        end

        // R1: set 1 is independent of set 0
        for (int t = 0; t < 4; t++) access(1'b0, la(t, 1, 1), 4'h0, 0, rd, w);
        for (int t = 0; t < 4; t++) begin
            access(1'b0, la(t, 0, 7), 4'h0, 0, rd, w);
            chk(w == 0, "R1 other set did not evict", 32'(w), 0);
        end

        // R4: byte-enable sweep on a hit, then dirty every way of set 0
        wb0 = wr_beats;
        for (int be = 0; be < 16; be++) begin
            wd = $urandom;
            access(1'b1, la(0, 0, 2), 4'(be), wd, rd, w);
            chk(w == 0, "R4 store hit no stall", 32'(w), 0);
            access(1'b0, la(0, 0, 2), 4'h0, 0, rd, w);
        end
        for (int t = 1; t < 4; t++) access(1'b1, la(t, 0, t), 4'hF, $urandom, rd, w);
        chk(wr_beats == wb0, "R4 no memory write on store hits", 32'(wr_beats), 32'(wb0));

        // R5 R7 R10: store miss to fifth tag with every way dirty
        wb0 = wr_beats; rb0 = rd_beats; wr_log_n = 0; first_rd_seq = 0;
        wd = 32'hCAFE_F00D;
        vaddr = la(4, 0, 5);
        access(1'b1, vaddr, 4'hF, wd, rd, w);
        chk(w > 0, "R5 store miss stalls", 32'(w), 1);
        chk(wr_beats - wb0 == 8, "R7 eight write-back beats", 32'(wr_beats - wb0), 8);
        chk(rd_beats - rb0 == 8, "R10 eight refill beats under stalls", 32'(rd_beats - rb0), 8);
        chk(last_wr_seq < first_rd_seq, "R7 write-back before refill", 32'(last_wr_seq), 32'(first_rd_seq));
        chk(wr_log[0][5:0] == 0 && wr_log[0] < 32'h100, "R7 victim line base", wr_log[0], 0);
        for (int k = 1; k < 8; k++)
            chk(wr_log[k] == wr_log[0] + 32'(4 * k), "R7 ascending beats", wr_log[k], wr_log[0] + 32'(4 * k));
        for (int k = 0; k < 8; k++) begin
            r = int'(wr_log[0][11:2]) + k;
            chk(bmem[r] == gold[r], "R7 written-back data", bmem[r], gold[r]);
        end
        chk(bmem[vaddr[11:2]] != wd, "R5 next level keeps old word", bmem[vaddr[11:2]], 0);
        access(1'b0, vaddr, 4'h0, 0, rd, w);
        chk(w == 0 && rd == wd, "R5 allocated line hits with stored data", rd, wd);

        // R8 R9: uncached accesses
        m0 = miss_seen;
        access(1'b0, 32'h4000_0004, 4'h0, 0, rd, w);
        chk(w > 0, "R8 bypass goes to memory", 32'(w), 1);
        dev[1] = 32'h1234_5678;
        access(1'b0, 32'h4000_0004, 4'h0, 0, rd, w);
        chk(rd == 32'h1234_5678, "R8 repeated read is live", rd, 32'h1234_5678);
        wb0 = wr_beats;
        access(1'b1, 32'h8000_0008, 4'b0011, 32'hAAAA_BBBB, rd, w);
        chk(dev[2] == 32'hD000_BBBB, "R8 bypass store byte enables", dev[2], 32'hD000_BBBB);
        chk(wr_beats - wb0 == 1, "R8 single-word transfer", 32'(wr_beats - wb0), 1);
        access(1'b0, 32'h4000_0000, 4'h0, 0, rd, w);
        chk(miss_seen == m0, "R9 no pulse for bypass", 32'(miss_seen), 32'(m0));
        for (int t = 0; t < 4; t++) begin
            access(1'b0, la(t, 1, 6), 4'h0, 0, rd, w);
            chk(w == 0, "R8 bypass did not allocate", 32'(w), 0);
        end
        m0 = miss_seen;
        access(1'b0, 32'h3FFF_FFE0, 4'h0, 0, rd, w);
        chk(miss_seen == m0 + 1, "R8 top cacheable address misses", 32'(miss_seen), 32'(m0 + 1));
        access(1'b0, 32'h3FFF_FFE4, 4'h0, 0, rd, w);
        chk(w == 0, "R8 top cacheable address allocated", 32'(w), 0);

        // near-exhaustive sweep: 8 tags x 2 sets x 8 words plus devices
        for (int n = 0; n < 1500; n++) begin
            if ($urandom % 8 == 0) dev[$urandom % 4] = $urandom;
            if ($urandom % 7 == 0)
                vaddr = 32'h4000_0000 | 32'(($urandom % 4) << 2);
            else
                vaddr = la($urandom % 8, $urandom % 2, $urandom % 8);
            access(1'($urandom), vaddr, 4'($urandom), $urandom, rd, w);
        end
        chk(miss_seen == miss_inferred, "R9 pulses equal cacheable misses", 32'(miss_seen), 32'(miss_inferred));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule